// File: doc/BRIEF.md
# GPIO Pad Control Register Bank

This block holds the control state for a group of general-purpose I/O pads behind a simple word-wide register port. Each pin owns two 32-bit control words. The first word carries the sampled input level, the output level, a direction field, a pad enable, a pull selection and a 4-bit interrupt line selector. The second word carries a trigger mode code and an input inversion flag. Software reads and writes these words through a request port. Read data comes back one cycle after the request.

Pin words are not laid out linearly. Pins are packed fifteen to a 1 KiB window, and the first window starts at byte offset 0x4400. The rest of each window is a gap that decodes to nothing. The bank drives each pad's output and output enable from the pin's enable, direction and output bits. It also feeds each pad's input through a two-flop synchroniser into the read-only input bit. The direction field gates both paths.

Top module: `gpio_padbank`

## Requirements
- R1: Word 0 of pin n sits at byte address 0x4400 + (n / 15) * 0x400 + (n mod 15) * 8, and word 1 sits 4 bytes above it. A read request returns its data on `rd_data`, with `rd_valid` high, in the cycle after the request is sampled. A write request never raises `rd_valid`.
- R2: The following addresses are unmapped: addresses below 0x4400, addresses with bits 1:0 non-zero, slots 15 and above within a window, and pins at or beyond `NUM_PINS`. A read of an unmapped address returns 0. A write to one changes no pin word.
- R3: Word 0 layout: bit 0 is the input level, bit 1 is the output level, bits 10:8 are the direction, bit 15 is the pad enable, bit 23 is the pull select (1 = up, 0 = down) and bits 31:28 are the interrupt line selector. All other bits read as 0.
- R4: Word 1 layout: bits 2:0 are the trigger mode and bit 6 is the input inversion flag. All other bits read as 0.
- R5: Writes to bit 0 of word 0 are ignored. The input bit changes only through sampling.
- R6: The direction field encodes as follows: 0 = input and output, 1 = output only, 2 = input only, 3 to 7 = neither. While input is allowed, the input bit follows the pad input through two synchroniser flops and then the bit register. A pad change is therefore readable three clock edges later.
- R7: While the direction does not allow input, the input bit holds its last value.
- R8: `pad_oe[n]` is 1 exactly when the pad enable is set and the direction allows output (0 or 1). It is registered, so it follows a configuration write by one cycle. `pad_out[n]` equals the output bit while `pad_oe[n]` is 1, and is 0 otherwise.
- R9: After reset, every pin word reads 0, `pad_oe` and `pad_out` are 0, and `rd_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Register request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 32 | Read data |
| pad_in | input | NUM_PINS | Raw pad input levels |
| pad_out | output | NUM_PINS | Pad output levels |
| pad_oe | output | NUM_PINS | Pad output enables |

## Verification
The input sampler and a software write can both update word 0 of the same pin in one clock edge. The bench raises a pin's pad input and schedules a word 0 write that clears bit 0 so that the write lands on the exact edge at which the synchronised level reaches the input bit. A readback must show the written fields together with the freshly sampled input level. This proves that neither update overwrites the other and that the write could not clear the input bit.

// File: rtl/gpio_padbank_pkg.sv
package gpio_padbank_pkg;
  localparam int unsigned PIN_BASE     = 32'h4400;
  localparam int unsigned PINS_PER_WIN = 15;
  localparam int unsigned WIN_SHIFT    = 10;
  localparam int unsigned SLOT_SHIFT   = 3;

  typedef enum logic [2:0] {
    DIR_BOTH    = 3'd0,
    DIR_OUT     = 3'd1,
    DIR_IN      = 3'd2,
    DIR_NONE    = 3'd3
  } dir_e;

  function automatic logic dir_rx_ok(input logic [2:0] d);
    return (d == DIR_BOTH) || (d == DIR_IN);
  endfunction

  function automatic logic dir_tx_ok(input logic [2:0] d);
    return (d == DIR_BOTH) || (d == DIR_OUT);
  endfunction
endpackage

// File: rtl/gpio_addr_decode.sv
module gpio_addr_decode
  import gpio_padbank_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int NUM_PINS = 20,
  parameter int PIN_W    = 5
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output logic [PIN_W-1:0]  pin_idx,
  output logic              word_sel
);
  localparam int NUM_WIN = (NUM_PINS + PINS_PER_WIN - 1) / PINS_PER_WIN;

  logic [ADDR_W-1:0] off;
  logic [ADDR_W-1:0] win;
  logic [ADDR_W-1:0] slot;
  logic [ADDR_W-1:0] lin;
  logic              in_range;

  always_comb begin
    in_range = addr >= ADDR_W'(PIN_BASE);
    off      = addr - ADDR_W'(PIN_BASE);
    win      = off >> WIN_SHIFT;
    slot     = ADDR_W'(off[WIN_SHIFT-1:SLOT_SHIFT]);
    lin      = win * ADDR_W'(PINS_PER_WIN) + slot;
    word_sel = off[2];
    hit      = in_range && (off[1:0] == 2'b00)
               && (slot < ADDR_W'(PINS_PER_WIN))
               && (win < ADDR_W'(NUM_WIN))
               && (lin < ADDR_W'(NUM_PINS));
    pin_idx  = lin[PIN_W-1:0];
  end
endmodule

// File: rtl/gpio_pin_cell.sv
module gpio_pin_cell
  import gpio_padbank_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        wr0,
  input  logic        wr1,
  input  logic [31:0] wdata,
  input  logic        pad_i,
  output logic [31:0] word0,
  output logic [31:0] word1,
  output logic        rx_en,
  output logic        rx_bit,
  output logic        pad_en,
  output logic        pad_o,
  output logic        pad_oe_o
);
  logic [3:0] irq_sel;
  logic       pull_up;
  logic       en;
  logic [2:0] dir;
  logic       tx;
  logic       rx;
  logic [2:0] trig;
  logic       inv;
  logic [1:0] sync;
  logic       drive;

  assign rx_en  = dir_rx_ok(dir);
  assign drive  = en & dir_tx_ok(dir);
  assign rx_bit = rx;
  assign pad_en = en;

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_sel <= '0; pull_up <= 1'b0; en <= 1'b0; dir <= '0; tx <= 1'b0;
      trig <= '0; inv <= 1'b0;
    end else begin
      if (wr0) begin
        irq_sel <= wdata[31:28];
        pull_up <= wdata[23];
        en      <= wdata[15];
        dir     <= wdata[10:8];
        tx      <= wdata[1];
      end
      if (wr1) begin
        trig <= wdata[2:0];
        inv  <= wdata[6];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sync <= '0;
      rx   <= 1'b0;
    end else begin
      sync <= {sync[0], pad_i};
      if (rx_en) rx <= sync[1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pad_oe_o <= 1'b0;
      pad_o    <= 1'b0;
    end else begin
      pad_oe_o <= drive;
      pad_o    <= drive & tx;
    end
  end

  assign word0 = {irq_sel, 4'b0, pull_up, 7'b0, en, 4'b0, dir, 6'b0, tx, rx};
  assign word1 = {25'b0, inv, 3'b0, trig};
endmodule

// File: rtl/gpio_padbank.sv
module gpio_padbank
  import gpio_padbank_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int NUM_PINS = 20
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                req_valid,
  input  logic                req_write,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [31:0]         req_wdata,
  output logic                rd_valid,
  output logic [31:0]         rd_data,
  input  logic [NUM_PINS-1:0] pad_in,
  output logic [NUM_PINS-1:0] pad_out,
  output logic [NUM_PINS-1:0] pad_oe
);
  localparam int PIN_W = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1;

  logic              dec_hit;
  logic [PIN_W-1:0]  dec_pin;
  logic              dec_word;
  logic [31:0]       w0_all [NUM_PINS];
  logic [31:0]       w1_all [NUM_PINS];
  logic [NUM_PINS-1:0] rx_en_v;
  logic [NUM_PINS-1:0] rx_bit_v;
  logic [NUM_PINS-1:0] pad_en_v;

  gpio_addr_decode #(.ADDR_W(ADDR_W), .NUM_PINS(NUM_PINS), .PIN_W(PIN_W)) u_dec (
    .addr(req_addr), .hit(dec_hit), .pin_idx(dec_pin), .word_sel(dec_word)
  );

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    logic sel;
    assign sel = req_valid & req_write & dec_hit & (dec_pin == PIN_W'(i));
    gpio_pin_cell u_cell (
      .clk(clk), .rst(rst),
      .wr0(sel & ~dec_word), .wr1(sel & dec_word),
      .wdata(req_wdata), .pad_i(pad_in[i]),
      .word0(w0_all[i]), .word1(w1_all[i]),
      .rx_en(rx_en_v[i]), .rx_bit(rx_bit_v[i]), .pad_en(pad_en_v[i]),
      .pad_o(pad_out[i]), .pad_oe_o(pad_oe[i])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= req_valid & ~req_write;
      if (req_valid && !req_write)
        rd_data <= !dec_hit ? 32'h0 : (dec_word ? w1_all[dec_pin] : w0_all[dec_pin]);
    end
  end
endmodule

// File: rtl/gpio_padbank_checker.sv
module gpio_padbank_checker #(
  parameter int NUM_PINS = 20
) (
  input logic                clk,
  input logic                rst,
  input logic                req_valid,
  input logic                req_write,
  input logic                dec_hit,
  input logic                rd_valid,
  input logic [31:0]         rd_data,
  input logic [NUM_PINS-1:0] rx_en_v,
  input logic [NUM_PINS-1:0] rx_bit_v,
  input logic [NUM_PINS-1:0] pad_en_v,
  input logic [NUM_PINS-1:0] pad_oe,
  input logic [NUM_PINS-1:0] pad_out
);
  a_r1_read_returns: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_write) |=> rd_valid);

  a_r1_write_silent: assert property (@(posedge clk) disable iff (rst)
    !(req_valid && !req_write) |=> !rd_valid);

  a_r2_unmapped_zero: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_write && !dec_hit) |=> (rd_data == 32'h0));

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_chk
    a_r7_rx_hold: assert property (@(posedge clk) disable iff (rst)
      !rx_en_v[i] |=> $stable(rx_bit_v[i]));
    a_r8_oe_needs_enable: assert property (@(posedge clk) disable iff (rst)
      !pad_en_v[i] |=> !pad_oe[i]);
    a_r8_out_quiet: assert property (@(posedge clk) disable iff (rst)
      !pad_oe[i] |-> !pad_out[i]);
  end
endmodule

bind gpio_padbank gpio_padbank_checker #(.NUM_PINS(NUM_PINS)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
  .dec_hit(dec_hit), .rd_valid(rd_valid), .rd_data(rd_data),
  .rx_en_v(rx_en_v), .rx_bit_v(rx_bit_v), .pad_en_v(pad_en_v),
  .pad_oe(pad_oe), .pad_out(pad_out)
);

// File: tb/gpio_padbank_bench.sv
`timescale 1ns/1ps
module gpio_padbank_bench;
  localparam int ADDR_W = 16;
  localparam int NP     = 20;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic rd_valid;
  logic [31:0] rd_data;
  logic [NP-1:0] pad_in = '0;
  logic [NP-1:0] pad_out, pad_oe;

  int checks = 0;
  int fails  = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #4 clk = ~clk;

  gpio_padbank #(.ADDR_W(ADDR_W), .NUM_PINS(NP)) u_gpio_padbank (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rd_valid(rd_valid),
    .rd_data(rd_data), .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
  );

  function automatic logic [ADDR_W-1:0] pa(input int n, input int w);
    return ADDR_W'(32'h4400 + (n / 15) * 32'h400 + (n % 15) * 8 + w * 4);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(posedge clk); @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, input logic [31:0] exp, input string tag);
    exp_q.push_back(exp); tag_q.push_back(tag);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(posedge clk); @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  // monitor: pops expected read data as results appear
  always @(negedge clk) begin
    if (!rst && rd_valid) begin
      if (exp_q.size() == 0) chk("R1 unexpected rd_valid", 32'h1, 32'h0);
      else chk(tag_q.pop_front(), rd_data, exp_q.pop_front());
    end
  end

  initial begin
    #(8 * 200000);
    chk("watchdog expired", 32'h1, 32'h0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    idle(3);
    rst = 1'b0;
    @(negedge clk);
    chk("R9 reset pad_oe", 32'(pad_oe), 32'h0);
    chk("R9 reset pad_out", 32'(pad_out), 32'h0);
    chk("R9 reset rd_valid", 32'(rd_valid), 32'h0);
    rd(pa(0, 0), 32'h0, "R9 reset word0 pin0");
    rd(pa(19, 1), 32'h0, "R9 reset word1 pin19");

    // R3 / R4 field layout and address map R1
    wr(pa(15, 0), 32'hFFFF_FFFF);
    wr(pa(14, 1), 32'hFFFF_FFFF);
    rd(pa(15, 0), 32'hF080_8702, "R3 word0 fields pin15 at 0x4800");
    rd(pa(14, 1), 32'h0000_0047, "R4 word1 fields pin14 at 0x4474");
    rd(pa(14, 0), 32'h0, "R1 word0 pin14 untouched");
    rd(pa(15, 1), 32'h0, "R1 word1 pin15 untouched");
    @(negedge clk);
    chk("R8 dir 7 no drive", 32'(pad_oe[15]), 32'h0);

    // R2 unmapped addresses
    wr(ADDR_W'(16'h4478), 32'hFFFF_FFFF);
    wr(ADDR_W'(16'h4828), 32'hFFFF_FFFF);
    rd(ADDR_W'(16'h4478), 32'h0, "R2 gap slot read");
    rd(ADDR_W'(16'h4828), 32'h0, "R2 pin beyond count read");
    rd(ADDR_W'(16'h0300), 32'h0, "R2 below base read");
    rd(ADDR_W'(16'h4401), 32'h0, "R2 unaligned read");
    rd(ADDR_W'(16'h4C00), 32'h0, "R2 window beyond count read");
    rd(pa(14, 0), 32'h0, "R2 gap write left pin14 alone");
    rd(pa(19, 0), 32'h0, "R2 gap write left pin19 alone");
    rd(pa(0, 0), 32'h0, "R2 gap write left pin0 alone");

    // R8 pad drive
    wr(pa(3, 0), 32'h0000_8002);
    chk("R8 oe lags write by a cycle", 32'(pad_oe[3]), 32'h0);
    @(negedge clk);
    chk("R8 oe both dirs", 32'(pad_oe[3]), 32'h1);
    chk("R8 out follows tx", 32'(pad_out[3]), 32'h1);
    wr(pa(3, 0), 32'h0000_8100);
    @(negedge clk);
    chk("R8 oe out only", 32'(pad_oe[3]), 32'h1);
    chk("R8 out low", 32'(pad_out[3]), 32'h0);
    wr(pa(3, 0), 32'h0000_8202);
    @(negedge clk);
    chk("R8 input only no oe", 32'(pad_oe[3]), 32'h0);
    chk("R8 no out when no oe", 32'(pad_out[3]), 32'h0);
    wr(pa(3, 0), 32'h0000_0002);
    @(negedge clk);
    chk("R8 disabled pad no oe", 32'(pad_oe[3]), 32'h0);

    // R6 / R7 input sampling
    pad_in[5] = 1'b1;
    idle(2);
    rd(pa(5, 0), 32'h0, "R6 not yet after two edges");
    rd(pa(5, 0), 32'h1, "R6 sampled after three edges");
    wr(pa(5, 0), 32'h0000_0300);
    pad_in[5] = 1'b0;
    idle(5);
    rd(pa(5, 0), 32'h0000_0301, "R7 hold with dir 3");
    wr(pa(5, 0), 32'h0000_0100);
    idle(5);
    rd(pa(5, 0), 32'h0000_0101, "R7 hold with dir 1");
    wr(pa(5, 0), 32'h0000_0200);
    idle(4);
    rd(pa(5, 0), 32'h0000_0200, "R6 follows with dir 2");

    // R5 write to input bit ignored
    wr(pa(6, 0), 32'h0000_0001);
    rd(pa(6, 0), 32'h0, "R5 write of rx bit ignored");

    // concurrent: write and sample update on the same edge (R5, R6)
    pad_in[7] = 1'b1;
    idle(2);
    wr(pa(7, 0), 32'h5000_8000);
    rd(pa(7, 0), 32'h5000_8001, "R5 R6 write and sample same edge");

    idle(3);
    while (exp_q.size() != 0) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule